// File: doc/BRIEF.md
# Bus-Transfer Routine Sequencer

The sequencer runs short microcoded routines. Each routine is a list of 24-bit instructions kept in a small program memory. A start pulse and a start address launch a routine. The block then steps through consecutive instructions until it completes one whose stop bit is set. Every instruction moves one 16-bit word over a shared data bus in one of four ways:

- from a register into the bus;
- from the bus into a register;
- from the bus into an internal FIFO;
- from the FIFO into the bus.

For each instruction the block drives an enable strobe with a high phase followed by a low phase. A 3-bit length code sets the length of each phase. The instruction also carries the levels of two control outputs and its own stop bit.

The program memory is written through a plain write port. Instruction fields decode as follows:

| Bits | Meaning |
|------|---------|
| 23:20 | Opcode |
| 13:8 | 6-bit register index |
| 7 | Direction |
| 6 | First control level |
| 5 | Second control level |
| 4 | Marker |
| 3 | Stop |
| 2:0 | Length code |

The next instruction is fetched during the final low clock of the current one, so consecutive instructions run back to back. Instructions whose upper twelve bits equal 0x300 pay a one-clock entry penalty. Faulty instructions and FIFO misuse raise sticky flags, which the next launch clears.

Top module: `xfer_seq`

## Requirements
- R1: While reset is held and after its release, busy_o, strobe_o, dq_oe_o, dq_o, illegal_o, underflow_o and overflow_o are 0, and cm_o and ec_o are 1.
- R2: A start_i pulse while idle loads the instruction at start_addr_i. busy_o is high from the next clock until the last low clock of the first instruction with bit 3 set. busy_o stays high for exactly the sum of all instruction lengths. A start_i pulse while busy is ignored.
- R3: Length code bits 2:0 set the strobe high and low clocks as follows: 000 gives 1 high and 1 low, 001 gives 1 and 2, 010 gives 1 and 3, 011 gives 2 and 1, and 100 gives 3 and 1. The high phase always comes first.
- R4: An instruction whose bits 23:12 equal 0x300 gets one extra high clock, unless the instruction executed just before it in the same routine also had bits 23:12 equal to 0x300.
- R5: During an instruction, cm_o equals bit 6 and ec_o equals bit 5. When idle, both are 1.
- R6: Opcode 0100 (bit 7 = 0) drives register {1, bits 13:8} on dq_o. dq_oe_o is high only during the low phase of read-out instructions (opcodes 0100 and 0110).
- R7: Opcode 0101 (bit 7 = 1) writes dq_i into register {1, bits 13:8}. dq_i is sampled at the clock that ends the low phase.
- R8: Opcode 0111 (bit 7 = 1) pushes dq_i, sampled at the end of the low phase. Opcode 0110 (bit 7 = 0) pops the FIFO and shows the popped word on dq_o, in first-in first-out order.
- R9: A pop from an empty FIFO drives dq_o to 0 and sets underflow_o.
- R10: A push into a full FIFO of FIFO_DEPTH words is dropped and sets overflow_o.
- R11: An instruction is illegal if its opcode lies outside 0100..0111, bit 4 is 0, bit 7 differs from bit 20, or its length code is 101..111. An illegal instruction moves no data, runs 1 high and 1 low (plus any R4 penalty), honours its stop bit and sets illegal_o.
- R12: illegal_o, underflow_o and overflow_o hold until a start_i pulse that launches a routine clears them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prog_we_i | input | 1 | Program memory write enable |
| prog_addr_i | input | PROG_AW | Program memory write address |
| prog_data_i | input | 24 | Instruction word to store |
| start_i | input | 1 | Launch pulse |
| start_addr_i | input | PROG_AW | First instruction address of the routine |
| dq_i | input | 16 | Data bus sampled by write-in instructions |
| busy_o | output | 1 | Routine in progress |
| strobe_o | output | 1 | Enable strobe, high phase then low phase |
| cm_o | output | 1 | First control level of the current instruction |
| ec_o | output | 1 | Second control level of the current instruction |
| dq_o | output | 16 | Data bus value for read-out instructions |
| dq_oe_o | output | 1 | Data bus output enable |
| illegal_o | output | 1 | Sticky illegal-instruction flag |
| underflow_o | output | 1 | Sticky FIFO underflow flag |
| overflow_o | output | 1 | Sticky FIFO overflow flag |

## Verification
The bench uses the default PROG_AW = 5 and FIFO_DEPTH = 4. The 32-word program memory holds every test routine at fixed addresses, so routines can be relaunched without reloading. A four-word FIFO becomes full after four single-push routines, which puts both the dropped fifth push and the pop from an empty FIFO within a few runs. Register index 63 exercises the top of the reachable register half. Back-to-back 0x300-class words show the entry penalty applied once and then waived.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int unsigned IW    = 24;
  localparam int unsigned DW    = 16;
  localparam int unsigned RA    = 6;
  localparam int unsigned RF_AW = RA + 1;

  typedef enum logic [1:0] {
    OP_R2D = 2'd0,
    OP_D2R = 2'd1,
    OP_F2D = 2'd2,
    OP_D2F = 2'd3
  } op_e;

  typedef struct packed {
    logic          vld;
    op_e           op;
    logic [RA-1:0] addr;
    logic          cm;
    logic          ec;
    logic          stop;
    logic          cls;
  } ins_t;
endpackage

// File: rtl/xfer_dec.sv
module xfer_dec
  import xfer_pkg::*;
(
  input  logic [IW-1:0] ins_i,
  output ins_t          d_o,
  output logic [1:0]    hi_o,
  output logic [1:0]    lo_o,
  output logic          bad_o
);
  logic op_ok, len_ok;

  always_comb begin
    op_ok  = (ins_i[23:22] == 2'b01) && (ins_i[7] == ins_i[20]) && ins_i[4];
    len_ok = (ins_i[2:0] <= 3'd4);
    bad_o  = !(op_ok && len_ok);
    hi_o   = 2'd1;
    lo_o   = 2'd1;
    if (!bad_o) begin
      case (ins_i[2:0])
        3'd1:    lo_o = 2'd2;
        3'd2:    lo_o = 2'd3;
        3'd3:    hi_o = 2'd2;
        3'd4:    hi_o = 2'd3;
        default: ;
      endcase
    end
    d_o.vld  = !bad_o;
    d_o.op   = op_e'(ins_i[21:20]);
    d_o.addr = ins_i[13:8];
    d_o.cm   = ins_i[6];
    d_o.ec   = ins_i[5];
    d_o.stop = ins_i[3];
    d_o.cls  = (ins_i[23:12] == 12'h300);
  end
endmodule

// File: rtl/xfer_fifo.sv
module xfer_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] nx(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rp_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= nx(wp_q);
      if (do_pop)  rp_q <= nx(rp_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= wdata_i;
  end

  assert_fifo_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  assert_full_push_dropped_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> $stable(cnt_q));
  assert_empty_pop_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> empty_o);
endmodule

// File: rtl/xfer_rf.sv
module xfer_rf #(
  parameter int unsigned W  = 16,
  parameter int unsigned AW = 7
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  localparam int unsigned N = 2 ** AW;

  logic [W-1:0] mem_q [N];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
  import xfer_pkg::*;
#(
  parameter int unsigned PROG_AW    = 5,
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               prog_we_i,
  input  logic [PROG_AW-1:0] prog_addr_i,
  input  logic [IW-1:0]      prog_data_i,
  input  logic               start_i,
  input  logic [PROG_AW-1:0] start_addr_i,
  input  logic [DW-1:0]      dq_i,
  output logic               busy_o,
  output logic               strobe_o,
  output logic               cm_o,
  output logic               ec_o,
  output logic [DW-1:0]      dq_o,
  output logic               dq_oe_o,
  output logic               illegal_o,
  output logic               underflow_o,
  output logic               overflow_o
);
  localparam int unsigned PDEPTH = 2 ** PROG_AW;

  typedef enum logic [1:0] {S_IDLE, S_HI, S_LO} st_e;

  logic [IW-1:0]      prog_q [PDEPTH];
  st_e                state_q;
  logic [PROG_AW-1:0] pc_q;
  logic [2:0]         cnt_q;
  ins_t               cur_q, nxt_d;
  logic [1:0]         lo_q, nxt_hi, nxt_lo;
  logic               nxt_bad;
  logic [IW-1:0]      nxt_ins;
  logic               launch, last_lo, advance, load, pen;
  logic               fifo_push, fifo_pop, fifo_empty, fifo_full, rf_we, rd_out;
  logic [DW-1:0]      fifo_rd, rf_rd;

  always_ff @(posedge clk_i) begin
    if (prog_we_i) prog_q[prog_addr_i] <= prog_data_i;
  end

  // look-ahead: decode the word that will run next
  assign nxt_ins = (state_q == S_IDLE) ? prog_q[start_addr_i] : prog_q[pc_q];

  xfer_dec u_dec (
    .ins_i (nxt_ins),
    .d_o   (nxt_d),
    .hi_o  (nxt_hi),
    .lo_o  (nxt_lo),
    .bad_o (nxt_bad)
  );

  assign launch  = (state_q == S_IDLE) && start_i;
  assign last_lo = (state_q == S_LO) && (cnt_q == 3'd1);
  assign advance = last_lo && !cur_q.stop;
  assign load    = launch || advance;
  assign pen     = nxt_d.cls && !(advance && cur_q.cls);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      pc_q    <= '0;
      cnt_q   <= '0;
      cur_q   <= '0;
      lo_q    <= '0;
    end else if (load) begin
      state_q <= S_HI;
      pc_q    <= (launch ? start_addr_i : pc_q) + PROG_AW'(1);
      cur_q   <= nxt_d;
      lo_q    <= nxt_lo;
      cnt_q   <= {1'b0, nxt_hi} + {2'b00, pen};
    end else begin
      case (state_q)
        S_HI: begin
          if (cnt_q == 3'd1) begin
            state_q <= S_LO;
            cnt_q   <= {1'b0, lo_q};
          end else begin
            cnt_q <= cnt_q - 3'd1;
          end
        end
        S_LO: begin
          if (cnt_q == 3'd1) state_q <= S_IDLE;
          else               cnt_q   <= cnt_q - 3'd1;
        end
        default: ;
      endcase
    end
  end

  assign fifo_push = last_lo && cur_q.vld && (cur_q.op == OP_D2F);
  assign fifo_pop  = last_lo && cur_q.vld && (cur_q.op == OP_F2D);
  assign rf_we     = last_lo && cur_q.vld && (cur_q.op == OP_D2R);
  assign rd_out    = cur_q.vld && ((cur_q.op == OP_R2D) || (cur_q.op == OP_F2D));

  xfer_fifo #(.DEPTH(FIFO_DEPTH), .W(DW)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (fifo_push),
    .pop_i   (fifo_pop),
    .wdata_i (dq_i),
    .rdata_o (fifo_rd),
    .empty_o (fifo_empty),
    .full_o  (fifo_full)
  );

  xfer_rf #(.W(DW), .AW(RF_AW)) u_rf (
    .clk_i   (clk_i),
    .we_i    (rf_we),
    .waddr_i ({1'b1, cur_q.addr}),
    .wdata_i (dq_i),
    .raddr_i ({1'b1, cur_q.addr}),
    .rdata_o (rf_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      illegal_o   <= 1'b0;
      underflow_o <= 1'b0;
      overflow_o  <= 1'b0;
    end else if (launch) begin
      illegal_o   <= nxt_bad;
      underflow_o <= 1'b0;
      overflow_o  <= 1'b0;
    end else begin
      if (advance && nxt_bad)       illegal_o   <= 1'b1;
      if (fifo_pop && fifo_empty)   underflow_o <= 1'b1;
      if (fifo_push && fifo_full)   overflow_o  <= 1'b1;
    end
  end

  assign busy_o   = (state_q != S_IDLE);
  assign strobe_o = (state_q == S_HI);
  assign cm_o     = busy_o ? cur_q.cm : 1'b1;
  assign ec_o     = busy_o ? cur_q.ec : 1'b1;
  assign dq_oe_o  = (state_q == S_LO) && rd_out;

  always_comb begin
    dq_o = '0;
    if (dq_oe_o) begin
      if (cur_q.op == OP_R2D)  dq_o = rf_rd;
      else if (!fifo_empty)    dq_o = fifo_rd;
    end
  end

  assert_oe_in_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> (busy_o && !strobe_o));
  assert_stop_halts_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_lo && cur_q.stop) |=> !busy_o);
  assert_start_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !last_lo) |=> busy_o);
  assert_phase_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (cnt_q >= 3'd1 && cnt_q <= 3'd4));
  assert_idle_ctrl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (cm_o && ec_o && !strobe_o && !dq_oe_o));
  assert_flag_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (illegal_o && !start_i) |=> illegal_o);
endmodule

// File: tb/tb_xfer_seq.sv
`timescale 1ns/1ps
module tb_xfer_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        prog_we_i = 1'b0;
  logic [4:0]  prog_addr_i = '0;
  logic [23:0] prog_data_i = '0;
  logic        start_i = 1'b0;
  logic [4:0]  start_addr_i = '0;
  logic [15:0] dq_i = '0;
  logic        busy_o, strobe_o, cm_o, ec_o, dq_oe_o;
  logic        illegal_o, underflow_o, overflow_o;
  logic [15:0] dq_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk_i = ~clk_i;

  xfer_seq #(.PROG_AW(5), .FIFO_DEPTH(4)) dut (
    .clk_i, .rst_ni, .prog_we_i, .prog_addr_i, .prog_data_i,
    .start_i, .start_addr_i, .dq_i,
    .busy_o, .strobe_o, .cm_o, .ec_o, .dq_o, .dq_oe_o,
    .illegal_o, .underflow_o, .overflow_o
  );

  localparam logic [3:0] R2D = 4'h4, D2R = 4'h5, F2D = 4'h6, D2F = 4'h7;

  function automatic logic [23:0] enc(input logic [3:0] op, input logic [5:0] a,
                                      input logic cm, input logic ec,
                                      input logic stop, input logic [2:0] len);
    return {op, 5'b0, 1'b1, a, op[0], cm, ec, 1'b1, stop, len};
  endfunction

  function automatic logic [23:0] c300(input logic stop, input logic [2:0] len);
    return {12'h300, 4'h0, 1'b0, 1'b1, 1'b1, 1'b1, stop, len};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard queues
  logic [31:0] exp_ph[$];
  string       exp_ph_tag[$];
  logic [15:0] exp_dq[$];
  string       exp_dq_tag[$];

  task automatic push_ph(input int hi, input int lo, input logic cm, input logic ec, input string tag);
    exp_ph.push_back({16'(hi), 4'(lo), 3'b0, cm, 7'b0, ec});
    exp_ph_tag.push_back(tag);
  endtask

  task automatic push_dq(input logic [15:0] d, input string tag);
    exp_dq.push_back(d);
    exp_dq_tag.push_back(tag);
  endtask

  // monitor
  int   hi_run = 0, lo_run = 0;
  logic s_cm, s_ec;
  logic prev_oe = 1'b0;

  task automatic close_run();
    logic [31:0] act;
    act = {16'(hi_run), 4'(lo_run), 3'b0, s_cm, 7'b0, s_ec};
    if (exp_ph.size() == 0) chk("R3 R4 R5 unexpected instruction", act, 32'hFFFF_FFFF);
    else chk(exp_ph_tag.pop_front(), act, exp_ph.pop_front());
    hi_run = 0;
    lo_run = 0;
  endtask

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (busy_o && strobe_o) begin
        if (lo_run > 0) close_run();
        hi_run++;
      end else if (busy_o) begin
        if (lo_run == 0) begin
          s_cm = cm_o;
          s_ec = ec_o;
        end
        lo_run++;
      end else if (hi_run > 0 || lo_run > 0) begin
        close_run();
      end
      if (dq_oe_o && !prev_oe) begin
        if (exp_dq.size() == 0) chk("R6 unexpected output enable", {16'h0, dq_o}, 32'hFFFF_FFFF);
        else chk(exp_dq_tag.pop_front(), {16'h0, dq_o}, {16'h0, exp_dq.pop_front()});
      end
      prev_oe = dq_oe_o;
    end
  end

  task automatic prog(input int a, input logic [23:0] d);
    @(negedge clk_i);
    prog_we_i = 1'b1;
    prog_addr_i = 5'(a);
    prog_data_i = d;
    @(negedge clk_i);
    prog_we_i = 1'b0;
  endtask

  task automatic go(input int a, input logic [15:0] d, input int total, input bit poke);
    int n;
    dq_i = d;
    @(negedge clk_i);
    start_i = 1'b1;
    start_addr_i = 5'(a);
    @(negedge clk_i);
    start_i = 1'b0;
    n = 0;
    while (busy_o && n < 100) begin
      n++;
      if (poke && n == 2) begin
        start_i = 1'b1;
        start_addr_i = 5'd16;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk_i);
    end
    start_i = 1'b0;
    chk("R2 busy length", 32'(n), 32'(total));
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset outputs", {24'h0, busy_o, strobe_o, dq_oe_o, illegal_o, underflow_o, overflow_o, cm_o, ec_o}, 32'h3);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after reset", {busy_o, strobe_o, dq_oe_o, illegal_o, underflow_o, overflow_o, cm_o, ec_o, dq_o}, {8'h03, 16'h0});

    prog(0,  enc(D2R, 6'd5, 1, 0, 0, 3'd1));
    prog(1,  enc(R2D, 6'd5, 0, 1, 1, 3'd3));
    prog(4,  enc(D2F, 6'd0, 1, 1, 1, 3'd2));
    prog(8,  enc(F2D, 6'd0, 0, 0, 0, 3'd4));
    prog(9,  enc(F2D, 6'd0, 1, 0, 0, 3'd0));
    prog(10, enc(F2D, 6'd0, 0, 1, 1, 3'd0));
    prog(12, c300(0, 3'd0));
    prog(13, c300(0, 3'd1));
    prog(14, enc(R2D, 6'd5, 1, 1, 1, 3'd0));
    prog(16, enc(R2D, 6'd5, 0, 0, 1, 3'd5));
    prog(17, enc(F2D, 6'd0, 0, 1, 1, 3'd0));
    prog(18, enc(D2R, 6'd63, 0, 1, 0, 3'd0));
    prog(19, enc(R2D, 6'd63, 1, 0, 1, 3'd2));

    // register write then read-back
    push_ph(1, 2, 1, 0, "R3 R5 len001");
    push_ph(2, 1, 0, 1, "R3 R5 len011");
    push_dq(16'hBEEF, "R7 R6 register write/read");
    go(0, 16'hBEEF, 6, 0);
    chk("R11 legal routine no flag", {31'h0, illegal_o}, 32'h0);

    // FIFO pushes
    push_ph(1, 3, 1, 1, "R3 len010");
    go(4, 16'h1111, 4, 0);
    push_ph(1, 3, 1, 1, "R3 len010");
    go(4, 16'h2222, 4, 0);
    chk("R10 no overflow below depth", {31'h0, overflow_o}, 32'h0);

    // FIFO pops including one from empty
    push_ph(3, 1, 0, 0, "R3 R5 len100");
    push_ph(1, 1, 1, 0, "R3 R5 len000");
    push_ph(1, 1, 0, 1, "R3 R5 len000");
    push_dq(16'h1111, "R8 fifo order first");
    push_dq(16'h2222, "R8 fifo order second");
    push_dq(16'h0000, "R9 empty pop drives zero");
    go(8, 16'h0, 8, 0);
    chk("R9 underflow flag", {31'h0, underflow_o}, 32'h1);

    push_ph(1, 3, 1, 1, "R3 len010");
    go(4, 16'h3333, 4, 0);
    chk("R12 underflow cleared by launch", {31'h0, underflow_o}, 32'h0);

    for (int i = 0; i < 3; i++) begin
      push_ph(1, 3, 1, 1, "R3 len010");
      go(4, 16'h4444 + 16'(i) * 16'h1111, 4, 0);
    end
    chk("R10 full without overflow", {31'h0, overflow_o}, 32'h0);
    push_ph(1, 3, 1, 1, "R3 len010");
    go(4, 16'h7777, 4, 0);
    chk("R10 overflow flag", {31'h0, overflow_o}, 32'h1);

    for (int i = 0; i < 4; i++) begin
      push_ph(1, 1, 0, 1, "R3 single pop");
      push_dq(16'h3333 + 16'(i) * 16'h1111, "R8 R10 drained order");
      go(17, 16'h0, 2, 0);
    end
    push_ph(1, 1, 0, 1, "R3 single pop");
    push_dq(16'h0000, "R10 dropped push absent");
    go(17, 16'h0, 2, 0);
    chk("R9 underflow after drain", {31'h0, underflow_o}, 32'h1);

    // 0x300 class penalty
    push_ph(2, 1, 1, 1, "R4 entry penalty");
    push_ph(1, 1, 1, 1, "R4 no repeat penalty");
    push_ph(1, 1, 1, 1, "R3 after class run");
    push_dq(16'hBEEF, "R6 read after class run");
    go(12, 16'h0, 7, 0);
    chk("R11 illegal from class words", {31'h0, illegal_o}, 32'h1);

    // bad length code
    push_ph(1, 1, 0, 0, "R11 bad length runs 1+1");
    go(16, 16'h0, 2, 0);
    chk("R11 illegal length flag", {31'h0, illegal_o}, 32'h1);

    // top register index
    push_ph(1, 1, 0, 1, "R3 R5 write top reg");
    push_ph(1, 3, 1, 0, "R3 R5 read top reg");
    push_dq(16'h1234, "R6 R7 register 127");
    go(18, 16'h1234, 6, 0);
    chk("R12 illegal cleared by launch", {31'h0, illegal_o}, 32'h0);

    // start while busy ignored
    push_ph(1, 2, 1, 0, "R2 poke len001");
    push_ph(2, 1, 0, 1, "R2 poke len011");
    push_dq(16'hCAFE, "R2 poke read");
    go(0, 16'hCAFE, 6, 1);
    chk("R2 ignored start left no flag", {31'h0, illegal_o}, 32'h0);

    repeat (3) @(negedge clk_i);
    chk("R5 idle control levels", {30'h0, cm_o, ec_o}, 32'h3);
    chk("R6 idle no drive", {15'h0, dq_oe_o, dq_o}, 32'h0);
    chk("R2 scoreboard drained", 32'(exp_ph.size() + exp_dq.size()), 32'h0);
    finish_up();
  end
endmodule